// File: doc/BRIEF.md
# Transfer Byte Counter with Threshold Flag

This block keeps a 64-bit running total of the bytes a DMA channel has moved to or from host memory, and raises a sticky threshold flag once that total reaches a programmable 64-bit compare value. Each completed host transfer presents its byte count on a valid-qualified input, and the block adds it to the total. Software sees the compare value, the live total and a latching view of the total as pairs of 32-bit words. The latching view lets a processor that only has 32-bit accesses read a coherent 64-bit value: reading its low word freezes a copy of the high word, and a later read of its high word returns that copy.

The threshold flag only sets while the comparator is armed. Arming comes from a strobe out of the channel operation register. When the total already meets the compare value at the moment of arming, the flag sets at once. The flag disarms the comparator when it fires. Any write to the compare value disarms the comparator and clears the flag, so a value that is half-written is never compared. A clear strobe zeroes the total. A channel-start pulse clears the flag.

Top module: `byte_tally`

## Requirements
- R1: After reset the total reads 0, the compare value reads 0, the flag is 0 and the comparator is disarmed.
- R2: On a clock edge with `xferValid` high, `xferBytes` (an unsigned count) is added to the 64-bit total. The new total reads back from the cycle after that edge. Word 0xA0 holds bits 31:0 and word 0xA4 holds bits 63:32.
- R3: `clrReq` zeroes the total at the next edge. It takes priority over a transfer in the same cycle.
- R4: `armReq` sets `armed`. `armed` stays 1 until the flag fires, and the edge that sets the flag also clears `armed`.
- R5: While armed, the flag sets on the first edge at which the registered total is greater than or equal to the compare value, compared as unsigned 64-bit numbers. That edge is one cycle after the edge on which the total reached the value.
- R6: If the total already meets the compare value when `armReq` is sampled, the flag sets on that same edge and `armed` never reads 1.
- R7: A write with any byte enable set to compare word 0x90 (bits 31:0) or 0x94 (bits 63:32) updates only the enabled bytes. It also clears both the flag and `armed`, and this includes an arm request made in the same cycle.
- R8: A read of word 0xA8 returns total bits 31:0 and captures total bits 63:32. A later read of word 0xAC returns that captured value, even after the total has moved on.
- R9: A read of an address outside 0x90, 0x94, 0xA0, 0xA4, 0xA8 and 0xAC returns 0.
- R10: When `armReq` and `clrReq` arrive in the same cycle, the total is cleared and the arm request is dropped.
- R11: A `chanStart` pulse clears the flag at the next edge, unless the comparator fires in that same cycle.
- R12: The flag is sticky. A total that reaches the compare value while the comparator is disarmed does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (a read of 0xA8 has a side effect) |
| regAddr | input | 8 | Register byte offset |
| regByteEn | input | 4 | Write byte enables |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr` (combinational) |
| xferValid | input | 1 | One completed host transfer this cycle |
| xferBytes | input | XFER_W | Bytes moved by that transfer |
| clrReq | input | 1 | Clear-total strobe |
| armReq | input | 1 | Arm-comparator strobe |
| chanStart | input | 1 | Channel start pulse |
| armed | output | 1 | Comparator armed |
| totalFlag | output | 1 | Threshold reached flag |

## Verification
The hardest situation to reach is a total whose high word is non-zero and then changes between a latching low read and the high read that follows. With increments of at most a few bytes, that would take hundreds of millions of cycles. The bench therefore widens `XFER_W` to 28 bits and adds near-maximum steps, which carries the total across 2^32 in a handful of transfers. The same large steps also set up the unsigned compare case, where the low word of the total is larger than the low word of the compare value but the high word is smaller. The remaining timing cases are placed cycle by cycle: arming when the total is already past the compare value, arming together with a clear, and writing the compare value while the comparator is armed.

// File: rtl/byte_tally_pkg.sv
package byte_tally_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] ADR_CMP_LO   = 8'h90;
  localparam logic [ADDR_W-1:0] ADR_CMP_HI   = 8'h94;
  localparam logic [ADDR_W-1:0] ADR_LIVE_LO  = 8'hA0;
  localparam logic [ADDR_W-1:0] ADR_LIVE_HI  = 8'hA4;
  localparam logic [ADDR_W-1:0] ADR_LATCH_LO = 8'hA8;
  localparam logic [ADDR_W-1:0] ADR_LATCH_HI = 8'hAC;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic cmpWrLo;
    logic cmpWrHi;
    logic capHi;
  } tallyStrb_t;
endpackage

// File: rtl/byte_tally_ctrl.sv
module byte_tally_ctrl
  import byte_tally_pkg::*;
#(
  parameter int REG_W = 32,
  localparam int NBYTES = REG_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [NBYTES-1:0] regByteEn,
  input  logic              clrReq,
  input  logic              armReq,
  input  logic              chanStart,
  input  logic              reached,
  output tallyStrb_t        strb,
  output logic              armed,
  output logic              totalFlag
);
  logic wrHit;
  logic cmpWr;
  logic armTake;
  logic fire;

  assign wrHit        = regWrEn && (|regByteEn);
  assign strb.cmpWrLo = wrHit && (regAddr == ADR_CMP_LO);
  assign strb.cmpWrHi = wrHit && (regAddr == ADR_CMP_HI);
  assign strb.capHi   = regRdEn && (regAddr == ADR_LATCH_LO);
  assign strb.clrCnt  = clrReq;

  assign cmpWr   = strb.cmpWrLo || strb.cmpWrHi;
  assign armTake = armReq && !clrReq;              // clear wins, arm dropped
  assign fire    = (armed || armTake) && reached && !cmpWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed     <= 1'b0;
      totalFlag <= 1'b0;
    end else if (cmpWr) begin
      armed     <= 1'b0;
      totalFlag <= 1'b0;
    end else if (fire) begin
      armed     <= 1'b0;
      totalFlag <= 1'b1;
    end else begin
      if (chanStart) totalFlag <= 1'b0;
      if (armTake)   armed     <= 1'b1;
    end
  end

  // R7: compare write leaves flag and arm clear
  a_r7_cmp_write_clears: assert property (@(posedge clk) disable iff (!rstN)
    cmpWr |=> (!totalFlag && !armed));

  // R5 / R12: flag only rises when the datapath reported the threshold reached
  a_r5_rise_needs_reach: assert property (@(posedge clk) disable iff (!rstN)
    $rose(totalFlag) |-> $past(reached));

  // R4: firing disarms
  a_r4_fire_disarms: assert property (@(posedge clk) disable iff (!rstN)
    $rose(totalFlag) |-> !armed);

  // R10: arm with clear is dropped
  a_r10_clr_drops_arm: assert property (@(posedge clk) disable iff (!rstN)
    (clrReq && armReq && !armed) |=> !armed);

  // R12: flag is sticky
  a_r12_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (totalFlag && !chanStart && !cmpWr) |=> totalFlag);
endmodule

// File: rtl/byte_tally_dp.sv
module byte_tally_dp
  import byte_tally_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int XFER_W = 4,
  localparam int CNT_W  = 2 * REG_W,
  localparam int NBYTES = REG_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  tallyStrb_t        strb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [NBYTES-1:0] regByteEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              xferValid,
  input  logic [XFER_W-1:0] xferBytes,
  output logic              reached
);
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] stepVal;
  logic [REG_W-1:0] cmpLo;
  logic [REG_W-1:0] cmpHi;
  logic [REG_W-1:0] latchHi;

  assign stepVal = xferValid ? CNT_W'(xferBytes) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            count <= '0;
    else if (strb.clrCnt) count <= '0;
    else                  count <= count + stepVal;
  end

  for (genvar g = 0; g < NBYTES; g++) begin : gCmpByte
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cmpLo[g*8 +: 8] <= '0;
        cmpHi[g*8 +: 8] <= '0;
      end else begin
        if (strb.cmpWrLo && regByteEn[g]) cmpLo[g*8 +: 8] <= regWrData[g*8 +: 8];
        if (strb.cmpWrHi && regByteEn[g]) cmpHi[g*8 +: 8] <= regWrData[g*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           latchHi <= '0;
    else if (strb.capHi) latchHi <= count[CNT_W-1:REG_W];
  end

  assign reached = (count >= {cmpHi, cmpLo});

  always_comb begin
    unique case (regAddr)
      ADR_CMP_LO:   regRdData = cmpLo;
      ADR_CMP_HI:   regRdData = cmpHi;
      ADR_LIVE_LO:  regRdData = count[REG_W-1:0];
      ADR_LIVE_HI:  regRdData = count[CNT_W-1:REG_W];
      ADR_LATCH_LO: regRdData = count[REG_W-1:0];
      ADR_LATCH_HI: regRdData = latchHi;
      default:      regRdData = '0;
    endcase
  end

  // R3: clear strobe leaves a zero total
  a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrCnt |=> (count == '0));

  // R2: total never decreases without a clear
  a_r2_no_decrease: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clrCnt |=> (count >= $past(count)));

  // R8: captured high word holds between latching reads
  a_r8_latch_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capHi |=> $stable(latchHi));
endmodule

// File: rtl/byte_tally.sv
module byte_tally
  import byte_tally_pkg::*;
#(
  parameter int XFER_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [7:0]        regAddr,
  input  logic [3:0]        regByteEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              xferValid,
  input  logic [XFER_W-1:0] xferBytes,
  input  logic              clrReq,
  input  logic              armReq,
  input  logic              chanStart,
  output logic              armed,
  output logic              totalFlag
);
  localparam int REG_W = 32;

  tallyStrb_t strb;
  logic       reached;

  byte_tally_ctrl #(.REG_W(REG_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regByteEn(regByteEn), .clrReq(clrReq),
    .armReq(armReq), .chanStart(chanStart), .reached(reached),
    .strb(strb), .armed(armed), .totalFlag(totalFlag)
  );

  byte_tally_dp #(.REG_W(REG_W), .XFER_W(XFER_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .regAddr(regAddr),
    .regByteEn(regByteEn), .regWrData(regWrData), .regRdData(regRdData),
    .xferValid(xferValid), .xferBytes(xferBytes), .reached(reached)
  );
endmodule

// File: tb/tb_byte_tally.sv
module tb_byte_tally;
  localparam int XW = 28;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 0, regRdEn = 0;
  logic [7:0] regAddr = '0;
  logic [3:0] regByteEn = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic xferValid = 0;
  logic [XW-1:0] xferBytes = '0;
  logic clrReq = 0, armReq = 0, chanStart = 0;
  logic armed, totalFlag;

  int nChecks = 0;
  int nFail = 0;
  logic [63:0] mdl = '0;

  always #10 clk = ~clk;

  byte_tally #(.XFER_W(XW)) dut (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rdReg(logic [7:0] a, output logic [31:0] d);
    regRdEn = 1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 0; regAddr = '0;
  endtask

  task automatic wrReg(logic [7:0] a, logic [31:0] d, logic [3:0] be);
    regWrEn = 1; regAddr = a; regWrData = d; regByteEn = be;
    @(negedge clk);
    regWrEn = 0; regAddr = '0; regByteEn = '0;
  endtask

  task automatic xfer(logic [XW-1:0] b);
    xferValid = 1; xferBytes = b;
    @(negedge clk);
    xferValid = 0;
    mdl = mdl + 64'(b);
  endtask

  task automatic clearCnt();
    clrReq = 1; @(negedge clk); clrReq = 0; mdl = '0;
  endtask

  task automatic armIt();
    armReq = 1; @(negedge clk); armReq = 0;
  endtask

  task automatic setCmp(logic [63:0] v);
    wrReg(8'h90, v[31:0], 4'hF);
    wrReg(8'h94, v[63:32], 4'hF);
  endtask

  task automatic chkLive(string tag);
    logic [31:0] lo, hi;
    rdReg(8'hA0, lo);
    rdReg(8'hA4, hi);
    chk(tag, {hi, lo}, mdl);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 flag", totalFlag, 0);
    chk("R1 armed", armed, 0);
    chkLive("R1 total");
    rdReg(8'h90, d); chk("R1 cmp lo", d, 0);
    rdReg(8'h94, d); chk("R1 cmp hi", d, 0);
  endtask

  task automatic t_count();
    setCmp(64'hFFFF_FFFF_FFFF_FFFF);
    clearCnt();
    xfer(8); xfer(3); xfer(0); xfer(5);
    chkLive("R2 small steps");
    xferValid = 0; xferBytes = 28'd99; @(negedge clk);
    chkLive("R2 invalid ignored");
    for (int i = 0; i < 20; i++) xfer(28'hFFF_FFFF);
    chkLive("R2 carry into high word");
  endtask

  task automatic t_clear();
    clrReq = 1; xferValid = 1; xferBytes = 28'd7;
    @(negedge clk);
    clrReq = 0; xferValid = 0; mdl = '0;
    chkLive("R3 clear beats transfer");
  endtask

  task automatic t_fire();
    clearCnt();
    setCmp(64'd100);
    armIt();
    chk("R4 armed set", armed, 1);
    xfer(96);
    chk("R12 below threshold", totalFlag, 0);
    xfer(4);
    chk("R5 one cycle latency", totalFlag, 0);
    @(negedge clk);
    chk("R5 flag set", totalFlag, 1);
    chk("R4 fire disarms", armed, 0);
    xfer(4); @(negedge clk);
    chk("R12 sticky", totalFlag, 1);
    chanStart = 1; @(negedge clk); chanStart = 0;
    chk("R11 start clears", totalFlag, 0);
  endtask

  task automatic t_immediate();
    clearCnt();
    setCmp(64'd10);
    xfer(20); @(negedge clk);
    chk("R12 unarmed no flag", totalFlag, 0);
    armIt();
    chk("R6 immediate flag", totalFlag, 1);
    chk("R6 never armed", armed, 0);
  endtask

  task automatic t_cmpwrite();
    logic [31:0] d;
    wrReg(8'h90, 32'h1122_3344, 4'hF);
    chk("R7 write clears flag", totalFlag, 0);
    wrReg(8'h94, 32'h0000_0001, 4'hF);
    armIt();
    chk("R7 armed before", armed, 1);
    wrReg(8'h90, 32'hAABB_CCDD, 4'b0010);
    chk("R7 write disarms", armed, 0);
    rdReg(8'h90, d); chk("R7 byte merge", d, 32'h1122_CC44);
    wrReg(8'h94, 32'hFFFF_FFFF, 4'h0);
    rdReg(8'h94, d); chk("R7 no enables no write", d, 32'h1);
    armReq = 1; regWrEn = 1; regAddr = 8'h94; regWrData = 32'h2; regByteEn = 4'h1;
    @(negedge clk);
    armReq = 0; regWrEn = 0; regAddr = '0; regByteEn = '0;
    chk("R7 arm with write dropped", armed, 0);
  endtask

  task automatic t_clr_arm();
    setCmp(64'hFFFF_FFFF_0000_0000);
    xfer(50);
    clrReq = 1; armReq = 1; @(negedge clk);
    clrReq = 0; armReq = 0; mdl = '0;
    chk("R10 arm dropped", armed, 0);
    chkLive("R10 total cleared");
  endtask

  task automatic t_unsigned();
    clearCnt();
    setCmp(64'h0000_0002_0000_0010);
    for (int i = 0; i < 24; i++) xfer(28'hFFF_FFFF);
    armIt(); @(negedge clk);
    chk("R5 unsigned below: low word larger", {mdl[63:32] < 2, totalFlag}, 2'b10);
    chk("R5 unsigned still armed", armed, 1);
    for (int i = 0; i < 12; i++) xfer(28'hFFF_FFFF);
    @(negedge clk);
    chk("R5 unsigned reached", totalFlag, 1);
  endtask

  task automatic t_latch();
    logic [31:0] lo, oldHi, d;
    clearCnt();
    for (int i = 0; i < 18; i++) xfer(28'hFFF_FFFF);
    rdReg(8'hA8, lo);
    oldHi = mdl[63:32];
    chk("R8 latch low word", lo, mdl[31:0]);
    for (int i = 0; i < 17; i++) xfer(28'hFFF_FFFF);
    rdReg(8'hAC, d); chk("R8 captured high", d, oldHi);
    rdReg(8'hA4, d); chk("R8 live high moved", d, mdl[63:32]);
    chk("R8 high changed", (d != oldHi), 1);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    rdReg(8'h00, d); chk("R9 unmapped 0x00", d, 0);
    rdReg(8'h98, d); chk("R9 unmapped 0x98", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_count();
    t_clear();
    t_fire();
    t_immediate();
    t_cmpwrite();
    t_clr_arm();
    t_unsigned();
    t_latch();
    t_unmapped();
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule